// File: doc/BRIEF.md
# Character-Serial Signed Decimal Field Adder

This block adds one signed decimal field (the addend, A) into a second signed decimal field (the accumulator, B) held in a character-addressed store. Each character is six bits wide. Both fields are addressed by their leftmost character, and each has a length code. The block walks both fields from the rightmost character leftward, one character per step. It reads through a simple single-port read/write interface with one cycle of read latency. The sum overwrites field B.

Numbers are sign-magnitude. Within a character, bits [3:0] hold one BCD digit, bit [4] is a zone flag and bit [5] is the sign flag. Only the sign flag of a field's rightmost character has meaning as a sign; 1 means negative. When the two signs match, the magnitudes are added. When they differ, A's magnitude is subtracted from B's. If that subtraction ends with a borrow, a second pass over the buffered digits forms the ten's complement and the result takes A's sign.

At the end the block pulses `done` for one cycle and holds a condition code on `cc` until the next operation. The block issues one operation at a time. It is driven by a controller that pulses `start` while the block is idle.

Top module: `decimal_field_adder`

## Requirements
- R1: A length code of 0 selects a 10-character field, and codes 1 to 9 select that many characters. The same rule applies to A and B.
- R2: Characters are processed from the rightmost character of each field toward the leftmost. Successive writes to B go to strictly descending addresses, and borrows and carries propagate leftward.
- R3: When A is shorter than B, the digit positions to the left of A are treated as zero, and no read is made outside A's field.
- R4: When A is longer than B, A's digits beyond B's length do not affect the result or the condition code. The block writes no location outside field B.
- R5: The addition is algebraic on sign-magnitude values, with the sign in bit [5] of the rightmost character and the digit in bits [3:0]. For example, +8 plus -1 gives +7.
- R6: In B's rightmost character the block writes the result sign to bit [5] and sets bit [4] to 1. Bits [5:4] of every other B character keep their prior values.
- R7: When same-sign magnitudes produce a carry out of B's leftmost digit, the carry is dropped, the truncated sum is written, and `cc` = 4.
- R8: Without overflow, `cc` = 1 for a negative non-zero result, 2 for a zero result and 3 for a positive non-zero result.
- R9: A result whose written magnitude is zero always carries a positive sign (bit [5] = 0).
- R10: After reset the block is idle, with `busy`, `done`, `mem_rd` and `mem_wr` low. `start` while idle raises `busy` on the next cycle. `done` is high for exactly one cycle per operation, and `mem_rd` and `mem_wr` are never high together.

States: IDLE (wait for `start`), RD_B (issue the read of a B character), RD_A (capture the B character and read the A character if one exists), ADD (add or subtract one digit into the buffer), WRITE (write back one character, complementing if needed), DONE (pulse `done`). The transitions are:
- IDLE to RD_B on `start`.
- RD_B to RD_A, then RD_A to ADD.
- ADD back to RD_B until the last B digit, then ADD to WRITE.
- WRITE stays in WRITE until the last B digit, then WRITE to DONE.
- DONE to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| a_addr | input | ADDR_W | Leftmost address of field A |
| a_code | input | LEN_W | Length code of A (0 means 10) |
| b_addr | input | ADDR_W | Leftmost address of field B |
| b_code | input | LEN_W | Length code of B (0 means 10) |
| mem_rdata | input | 6 | Read data, valid the cycle after `mem_rd` |
| mem_addr | output | ADDR_W | Store address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 6 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cc | output | 3 | Condition code: 1 negative, 2 zero, 3 positive, 4 overflow |

## Verification
The in-line assertions check the following on every cycle:
- `done` lasts a single cycle, `start` raises `busy`, and read and write never coincide.
- Writes fall only inside field B and at descending addresses.
- The rightmost written character has bit [4] set, and a zero magnitude is written positive.
- An overflow code appears only with matching signs.

Only the bench's scenarios can show that the stored digits and the condition code equal the arithmetic sum. These scenarios are a sweep over every length pair from 1 to 4, plus directed 10-digit, truncation, zero-extension, borrow-chain and complement cases. The same scenarios check that the zone bits are preserved and that A and the surrounding store are left untouched.

// File: rtl/dfa_pkg.sv
package dfa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD_B  = 3'd1,
        ST_RD_A  = 3'd2,
        ST_ADD   = 3'd3,
        ST_WRITE = 3'd4,
        ST_DONE  = 3'd5
    } dfa_state_t;

    localparam logic [2:0] CC_NEG  = 3'd1;
    localparam logic [2:0] CC_ZERO = 3'd2;
    localparam logic [2:0] CC_POS  = 3'd3;
    localparam logic [2:0] CC_OVF  = 3'd4;

    localparam int CHAR_W  = 6;
    localparam int DIGIT_W = 4;

endpackage

// File: rtl/dfa_len_decode.sv
// Turns a field length code into a character count; code 0 means MAX_LEN.
module dfa_len_decode #(
    parameter int MAX_LEN = 10,
    parameter int LEN_W   = 4
) (
    input  logic [LEN_W-1:0] code,
    output logic [LEN_W-1:0] len
);
    localparam logic [LEN_W-1:0] FULL = LEN_W'(MAX_LEN);

    always_comb begin
        if (code == '0 || code > FULL) begin
            len = FULL;
        end else begin
            len = code;
        end
    end
endmodule

// File: rtl/dfa_digit_step.sv
// One BCD digit step: x + y + cin, or x - y - cin when sub is set.
module dfa_digit_step (
    input  logic [3:0] x,
    input  logic [3:0] y,
    input  logic       cin,
    input  logic       sub,
    output logic [3:0] r,
    output logic       cout
);
    logic [5:0] sum6;
    logic [5:0] dif6;
    logic [5:0] fix6;

    always_comb begin
        sum6 = {2'b00, x} + {2'b00, y} + {5'b0, cin};
        dif6 = {2'b00, x} - {2'b00, y} - {5'b0, cin};
        fix6 = '0;
        if (sub) begin
            if (dif6[5]) begin
                fix6 = dif6 + 6'd10;
                cout = 1'b1;
            end else begin
                fix6 = dif6;
                cout = 1'b0;
            end
        end else begin
            if (sum6 > 6'd9) begin
                fix6 = sum6 - 6'd10;
                cout = 1'b1;
            end else begin
                fix6 = sum6;
                cout = 1'b0;
            end
        end
        r = fix6[3:0];
    end
endmodule

// File: rtl/decimal_field_adder.sv
module decimal_field_adder
    import dfa_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int MAX_LEN = 10,
    parameter int LEN_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [LEN_W-1:0]  a_code,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [LEN_W-1:0]  b_code,
    input  logic [5:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [5:0]        mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [2:0]        cc
);
    localparam logic [LEN_W-1:0]  ONE_L = LEN_W'(1);
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

    dfa_state_t st_q, st_d;

    logic [ADDR_W-1:0] a_base_q, b_base_q;
    logic [LEN_W-1:0]  a_len_q, b_len_q, a_len_d, b_len_d;
    logic [LEN_W-1:0]  idx_q;
    logic [5:0]        b_char_q;
    logic              a_take_q, a_sign_q, b_sign_q, sub_q;
    logic              cy_q, nz_q, wb_q;
    logic [2:0]        cc_q;
    logic [5:0]        res_q [MAX_LEN];

    logic              last_idx, a_live, sub_now;
    logic [3:0]        a_dig, alu_r, cpl_r, out_dig;
    logic              alu_c, cpl_c;
    logic              cmpl, ovf, res_sign;
    logic [2:0]        cc_calc;
    logic [ADDR_W-1:0] a_pos, b_pos, b_last;
    logic [5:0]        cur_char, wr_char;

    dfa_len_decode #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_alen (.code(a_code), .len(a_len_d));
    dfa_len_decode #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_blen (.code(b_code), .len(b_len_d));

    // Field walk: offsets count from the rightmost character.
    always_comb begin
        last_idx = (idx_q == b_len_q - ONE_L);
        a_live   = (idx_q < a_len_q);
        a_pos    = a_base_q + ADDR_W'(a_len_q) - ONE_A - ADDR_W'(idx_q);
        b_pos    = b_base_q + ADDR_W'(b_len_q) - ONE_A - ADDR_W'(idx_q);
        b_last   = b_base_q + ADDR_W'(b_len_q) - ONE_A;
        sub_now  = (idx_q == '0) ? (mem_rdata[5] ^ b_sign_q) : sub_q;
        a_dig    = a_take_q ? mem_rdata[3:0] : 4'd0;
    end

    // Digit adder for the first pass, complementer for the write pass.
    dfa_digit_step u_add (
        .x(b_char_q[3:0]), .y(a_dig), .cin(cy_q), .sub(sub_now),
        .r(alu_r), .cout(alu_c)
    );

    dfa_digit_step u_cpl (
        .x(4'd0), .y(cur_char[3:0]), .cin(wb_q), .sub(1'b1),
        .r(cpl_r), .cout(cpl_c)
    );

    // Result sign and condition code, settled once the first pass ends.
    always_comb begin
        cmpl     = sub_q & cy_q;
        ovf      = ~sub_q & cy_q;
        res_sign = nz_q & (cmpl ? a_sign_q : b_sign_q);
        if (ovf) begin
            cc_calc = CC_OVF;
        end else if (!nz_q) begin
            cc_calc = CC_ZERO;
        end else if (res_sign) begin
            cc_calc = CC_NEG;
        end else begin
            cc_calc = CC_POS;
        end
        cur_char = res_q[idx_q];
        out_dig  = cmpl ? cpl_r : cur_char[3:0];
        if (idx_q == '0) begin
            wr_char = {res_sign, 1'b1, out_dig};
        end else begin
            wr_char = {cur_char[5:4], out_dig};
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_RD_B;
            ST_RD_B:  st_d = ST_RD_A;
            ST_RD_A:  st_d = ST_ADD;
            ST_ADD:   st_d = last_idx ? ST_WRITE : ST_RD_B;
            ST_WRITE: st_d = last_idx ? ST_DONE : ST_WRITE;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        mem_rd    = (st_q == ST_RD_B) || ((st_q == ST_RD_A) && a_live);
        mem_wr    = (st_q == ST_WRITE);
        mem_addr  = (st_q == ST_RD_A) ? a_pos : b_pos;
        mem_wdata = wr_char;
        busy      = (st_q != ST_IDLE);
        done      = (st_q == ST_DONE);
        cc        = cc_q;
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_base_q <= '0;
            b_base_q <= '0;
            a_len_q  <= ONE_L;
            b_len_q  <= ONE_L;
            idx_q    <= '0;
            b_char_q <= '0;
            a_take_q <= 1'b0;
            a_sign_q <= 1'b0;
            b_sign_q <= 1'b0;
            sub_q    <= 1'b0;
            cy_q     <= 1'b0;
            nz_q     <= 1'b0;
            wb_q     <= 1'b0;
            cc_q     <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        a_base_q <= a_addr;
                        b_base_q <= b_addr;
                        a_len_q  <= a_len_d;
                        b_len_q  <= b_len_d;
                        idx_q    <= '0;
                        cy_q     <= 1'b0;
                        nz_q     <= 1'b0;
                        wb_q     <= 1'b0;
                    end
                end
                ST_RD_B: begin
                end
                ST_RD_A: begin
                    b_char_q <= mem_rdata;
                    a_take_q <= a_live;
                    if (idx_q == '0) b_sign_q <= mem_rdata[5];
                end
                ST_ADD: begin
                    cy_q <= alu_c;
                    nz_q <= nz_q | (alu_r != 4'd0);
                    if (idx_q == '0) begin
                        a_sign_q <= mem_rdata[5];
                        sub_q    <= sub_now;
                    end
                    idx_q <= last_idx ? '0 : idx_q + ONE_L;
                    wb_q  <= 1'b0;
                end
                ST_WRITE: begin
                    wb_q  <= cpl_c;
                    idx_q <= last_idx ? '0 : idx_q + ONE_L;
                    if (last_idx) cc_q <= cc_calc;
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Result buffer: one slot per digit position, filled during the first pass.
    for (genvar g = 0; g < MAX_LEN; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q[g] <= '0;
            end else if (st_q == ST_ADD && idx_q == LEN_W'(g)) begin
                res_q[g] <= {b_char_q[5:4], alu_r};
            end
        end
    end

    // R10: done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: read and write strobes are exclusive
    a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R10: start from idle makes the block busy
    a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2: consecutive writes step leftward
    a_r2_write_descends: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) - ONE_A));

    // R4: writes stay inside field B
    a_r4_write_in_b: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ((mem_addr >= b_base_q) && (mem_addr <= b_last)));

    // R6: rightmost character carries the zone flag
    a_r6_right_zone: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_addr == b_last) |-> mem_wdata[4]);

    // R9: zero magnitude is written positive
    a_r9_zero_positive: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_addr == b_last && !nz_q) |-> !mem_wdata[5]);

    // R7: overflow only arises from like signs
    a_r7_ovf_like_signs: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cc == CC_OVF) |-> (a_sign_q == b_sign_q));

    // R8: condition code is one of the four legal values at completion
    a_r8_cc_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cc >= CC_NEG && cc <= CC_OVF));

endmodule

// File: tb/sim_decimal_field_adder.sv
module sim_decimal_field_adder;
    localparam int AW = 6;
    localparam int A_AT = 4;
    localparam int B_AT = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [3:0]    a_code = '0, b_code = '0;
    logic [5:0]    mem_rdata = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr, busy, done;
    logic [5:0]    mem_wdata;
    logic [2:0]    cc;

    logic [5:0] mem  [64];
    logic [5:0] snap [64];

    int n_tests = 0;
    int n_fail  = 0;
    bit [63:0] seed = 64'h1234_5678_9abc_def1;

    always #2 clk = ~clk;

    decimal_field_adder #(.ADDR_W(AW), .MAX_LEN(10), .LEN_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_addr(a_addr), .a_code(a_code), .b_addr(b_addr), .b_code(b_code),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .busy(busy), .done(done), .cc(cc)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    function automatic longint rnd();
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        return longint'(seed >> 33);
    endfunction

    function automatic longint p10(int n);
        longint v = 1;
        for (int i = 0; i < n; i++) v = v * 10;
        return v;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_add(input int la, input int lb, input longint am, input bit an,
                          input longint bm, input bit bn, input string tag);
        longint av, md, s, mag, dig;
        bit sg, ovf;
        int ecc, bad_f, bad_o, j, p;
        logic [5:0] ex, first_act, first_exp;
        logic [5:0] oa, oe;
        for (int k = 0; k < 64; k++) mem[k] = 6'(rnd());
        for (int k = 0; k < la; k++) begin
            j = la - 1 - k;
            mem[A_AT + k][3:0] = 4'((am / p10(j)) % 10);
            if (j == 0) mem[A_AT + k][5] = an;
        end
        for (int k = 0; k < lb; k++) begin
            j = lb - 1 - k;
            mem[B_AT + k][3:0] = 4'((bm / p10(j)) % 10);
            if (j == 0) mem[B_AT + k][5] = bn;
        end
        for (int k = 0; k < 64; k++) snap[k] = mem[k];
        md = p10(lb);
        av = am % md;
        ovf = 1'b0;
        if (an == bn) begin
            s = av + bm;
            ovf = (s >= md);
            mag = s % md;
            sg = bn;
        end else begin
            s = bm - av;
            mag = (s < 0) ? -s : s;
            sg = (s < 0) ? an : bn;
        end
        if (mag == 0) sg = 1'b0;
        ecc = ovf ? 4 : (mag == 0) ? 2 : sg ? 1 : 3;

        @(negedge clk);
        a_addr = AW'(A_AT);
        b_addr = AW'(B_AT);
        a_code = 4'((la == 10) ? 0 : la);
        b_code = 4'((lb == 10) ? 0 : lb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);

        check(int'(cc) == ecc, ovf ? "R7" : "R8", {tag, " cc"}, longint'(cc), longint'(ecc));
        bad_f = 0;
        bad_o = 0;
        first_act = '0; first_exp = '0; oa = '0; oe = '0;
        for (int k = 0; k < 64; k++) begin
            if (k >= B_AT && k < B_AT + lb) begin
                p = k - B_AT;
                j = lb - 1 - p;
                dig = (mag / p10(j)) % 10;
                ex = {snap[k][5:4], 4'(dig)};
                if (j == 0) ex = {sg, 1'b1, 4'(dig)};
                if (mem[k] !== ex) begin
                    if (bad_f == 0) begin first_act = mem[k]; first_exp = ex; end
                    bad_f++;
                end
            end else if (mem[k] !== snap[k]) begin
                if (bad_o == 0) begin oa = mem[k]; oe = snap[k]; end
                bad_o++;
            end
        end
        check(bad_f == 0, "R5/R6", {tag, " B field char"}, longint'(first_act), longint'(first_exp));
        check(bad_o == 0, "R4", {tag, " outside B"}, longint'(oa), longint'(oe));
        @(negedge clk);
        check(!done, "R10", {tag, " done width"}, longint'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R10 watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_rd && !mem_wr, "R10", "reset state",
              longint'({busy, done, mem_rd, mem_wr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R10", "idle after reset", longint'(busy), 0);

        // R5: +8 plus -1 gives +7
        do_add(1, 1, 1, 1'b1, 8, 1'b0, "R5 eight minus one");
        // R9: equal and opposite values give positive zero
        do_add(2, 2, 25, 1'b1, 25, 1'b0, "R9 cancel");
        do_add(2, 2, 25, 1'b0, 25, 1'b1, "R9 cancel flipped");
        // Complement pass: +3 plus -50 gives -47
        do_add(2, 2, 50, 1'b1, 3, 1'b0, "R8 complement");
        // R7: 99 + 1 in two digits
        do_add(1, 2, 1, 1'b0, 99, 1'b0, "R7 carry drop");
        do_add(2, 2, 7, 1'b1, 95, 1'b1, "R7 negative carry");
        // R4: extra leading A digits ignored
        do_add(5, 2, 12399, 1'b0, 1, 1'b0, "R4 long A");
        do_add(4, 1, 9993, 1'b1, 5, 1'b0, "R4 long A sub");
        // R3: short A zero-extended; R2: borrow ripples leftward
        do_add(1, 5, 1, 1'b1, 10000, 1'b0, "R3 R2 borrow chain");
        do_add(1, 4, 9, 1'b0, 991, 1'b0, "R3 R2 carry chain");
        // R1: code 0 is ten characters
        do_add(10, 10, 64'd9876543210, 1'b0, 64'd123456789, 1'b0, "R1 ten digits");
        do_add(10, 10, 64'd9999999999, 1'b1, 64'd1, 1'b1, "R1 ten digit overflow");
        do_add(10, 3, 64'd5555555123, 1'b1, 500, 1'b0, "R1 R4 ten to three");
        do_add(9, 10, 64'd999999999, 1'b0, 64'd9000000001, 1'b1, "R1 nine into ten");

        // Sweep of all length pairs up to 4 with mixed sign patterns (R5, R8)
        for (int la = 1; la <= 4; la++) begin
            for (int lb = 1; lb <= 4; lb++) begin
                for (int pat = 0; pat < 6; pat++) begin
                    longint am = rnd() % p10(la);
                    longint bm = rnd() % p10(lb);
                    if (pat == 5) am = bm;
                    do_add(la, lb, am, pat[0], bm, pat[1] ^ (pat == 5), "R5 sweep");
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule